// File: doc/BRIEF.md
# Two-Phase Sync Edge Steering

This block turns one external synchronization pin into cycle-start strobes for a pair of switching-converter channels that run half a period apart. The pin is brought into the system clock domain and its falling edges are found. Each edge becomes a one-clock start strobe that goes to channel 1 and channel 2 in turn, so each channel switches at half the edge rate and 180 degrees from the other.

When no edge arrives for a programmable number of clocks, an internal period counter takes over and issues the alternating starts itself. The first external edge after that hand-over ends the internal pacing and starts the sequence again at channel 1. If the pin stays high for a configured run of clocks, the block asks for forced-PWM operation. That request is taken only at a cycle start. It is dropped at the first cycle start that sees the pin low again.

Top module: `sync_phase_steer`

## Requirements
- R1: After reset, the first falling edge on `sync_in` produces a pulse on `start_ch1`.
- R2: Each later cycle start goes to the other channel: `start_ch1`, `start_ch2`, `start_ch1`, and so on.
- R3: A start pulse is exactly one clock wide. It is first visible after the third rising clock edge that follows a fall of `sync_in` (two synchronizer flops, then the output register).
- R4: `sync_in` may switch as often as every 2 clocks (2 high, 2 low). Every such falling edge gives exactly one start pulse.
- R5: With no falling edge, the first internal start comes `timeout_cycles + int_period` clocks after the last external start pulse. Further internal starts follow every `int_period` clocks and keep alternating.
- R6: A falling edge that arrives while internal pacing is active produces `start_ch1` and ends internal pacing. The edge after it goes to `start_ch2`.
- R7: `start_ch1` and `start_ch2` are never high in the same clock.
- R8: Once `sync_in` has been high for `HIGH_HOLD` consecutive synchronized samples, `force_pwm` rises together with the next start pulse. `force_pwm` never changes in a clock that has no start pulse.
- R9: `force_pwm` falls together with the first start pulse whose triggering sample of `sync_in` is low, which is the start caused by the falling edge. `force_pwm` stays low while `sync_in` switches with high phases shorter than `HIGH_HOLD`.
- R10: Synchronous active-high `rst` clears both start outputs and `force_pwm`, and points the steering back at channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | External synchronization pin, asynchronous |
| timeout_cycles | input | TMO_W | Clocks without an edge before internal pacing starts |
| int_period | input | PER_W | Internal pacing period in clocks |
| start_ch1 | output | 1 | One-clock cycle-start strobe, channel 1 |
| start_ch2 | output | 1 | One-clock cycle-start strobe, channel 2 |
| force_pwm | output | 1 | Forced-PWM request, changes only at a start strobe |

## Verification
An external fall shows up on a start output three clock edges after the pin changes. The bench drives the pin on a falling clock edge, samples on the falling edge two clocks later to confirm the output is still quiet, then samples once more to see the strobe. An internal start is due exactly `timeout_cycles + int_period` clocks after the last external strobe, and the bench checks that offset and each later gap of `int_period` clocks. The forced-PWM flag is checked at every sample while the pin is held high, so that each change of the flag is seen in the same sample as a start strobe.

// File: rtl/sps_pkg.sv
package sps_pkg;

  // true when a counter has reached the last count of a limit; a limit of zero acts as one
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    if (lim == 32'd0) return 1'b1;
    return cnt >= (lim - 32'd1);
  endfunction

  // which channel receives a start: restart forces channel 1
  function automatic logic pick_ch2(input logic restart, input logic next_is_ch2);
    return !restart && next_is_ch2;
  endfunction

endpackage

// File: rtl/sps_edge.sv
module sps_edge #(
  parameter int HIGH_HOLD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic fall_evt,
  output logic lvl,
  output logic high_req
);
  localparam int HW = $clog2(HIGH_HOLD + 1);

  logic s1, s2, s3;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sync_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !s2) hold_cnt <= '0;
    else if (hold_cnt != HW'(HIGH_HOLD)) hold_cnt <= hold_cnt + 1'b1;
  end

  assign fall_evt = s3 & ~s2;
  assign lvl      = s2;
  assign high_req = s2 && (hold_cnt == HW'(HIGH_HOLD));

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst) fall_evt |=> !fall_evt);

endmodule

// File: rtl/sps_pacer.sv
module sps_pacer
  import sps_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_evt,
  input  logic [TMO_W-1:0] timeout_cycles,
  input  logic [PER_W-1:0] int_period,
  output logic             fallback,
  output logic             tick
);
  logic [TMO_W-1:0] quiet_cnt;
  logic [PER_W-1:0] per_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_cnt <= '0;
      per_cnt   <= '0;
      fallback  <= 1'b0;
    end else if (fall_evt) begin
      quiet_cnt <= '0;
      per_cnt   <= '0;
      fallback  <= 1'b0;
    end else if (!fallback) begin
      if (at_limit(32'(quiet_cnt), 32'(timeout_cycles))) begin
        fallback <= 1'b1;
        per_cnt  <= '0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end else begin
      per_cnt <= tick ? '0 : per_cnt + 1'b1;
    end
  end

  assign tick = fallback && at_limit(32'(per_cnt), 32'(int_period));

  // R6
  fall_ends_fallback_chk: assert property (@(posedge clk) disable iff (rst) fall_evt |=> !fallback);
  // R5
  fallback_quiet_chk: assert property (@(posedge clk) disable iff (rst) $rose(fallback) |-> !$past(fall_evt));

endmodule

// File: rtl/sps_steer.sv
module sps_steer
  import sps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fall_evt,
  input  logic fallback,
  input  logic tick,
  output logic cycle_start,
  output logic start_a,
  output logic start_b
);
  logic next_b;
  logic restart;
  logic to_b;

  assign cycle_start = fall_evt | tick;
  assign restart     = fall_evt & fallback;
  assign to_b        = pick_ch2(restart, next_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_b  <= 1'b0;
      start_a <= 1'b0;
      start_b <= 1'b0;
    end else begin
      start_a <= cycle_start & ~to_b;
      start_b <= cycle_start & to_b;
      if (cycle_start) next_b <= ~to_b;
    end
  end

  // R7
  starts_mutex_chk: assert property (@(posedge clk) disable iff (rst) !(start_a && start_b));
  // R2
  one_start_chk: assert property (@(posedge clk) disable iff (rst) cycle_start |=> (start_a ^ start_b));
  // R6
  restart_ch1_chk: assert property (@(posedge clk) disable iff (rst) restart |=> start_a);
  // R10
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!start_a && !start_b));

endmodule

// File: rtl/sps_mode.sv
module sps_mode (
  input  logic clk,
  input  logic rst,
  input  logic cycle_start,
  input  logic lvl,
  input  logic high_req,
  output logic force_pwm
);
  always_ff @(posedge clk) begin
    if (rst) force_pwm <= 1'b0;
    else if (cycle_start) begin
      if (high_req) force_pwm <= 1'b1;
      else if (!lvl) force_pwm <= 1'b0;
    end
  end

  // R8
  force_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(force_pwm) |-> ($past(cycle_start) && $past(high_req)));
  // R9
  force_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(force_pwm) |-> ($past(cycle_start) && !$past(lvl)));
  // R10
  reset_mode_chk: assert property (@(posedge clk) rst |=> !force_pwm);

endmodule

// File: rtl/sync_phase_steer.sv
module sync_phase_steer #(
  parameter int TMO_W     = 16,
  parameter int PER_W     = 16,
  parameter int HIGH_HOLD = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic [TMO_W-1:0] timeout_cycles,
  input  logic [PER_W-1:0] int_period,
  output logic             start_ch1,
  output logic             start_ch2,
  output logic             force_pwm
);
  logic fall_evt, lvl, high_req;
  logic fallback, tick, cycle_start;

  sps_edge #(.HIGH_HOLD(HIGH_HOLD)) u_edge (
    .clk(clk), .rst(rst), .sync_in(sync_in),
    .fall_evt(fall_evt), .lvl(lvl), .high_req(high_req)
  );

  sps_pacer #(.TMO_W(TMO_W), .PER_W(PER_W)) u_pacer (
    .clk(clk), .rst(rst), .fall_evt(fall_evt),
    .timeout_cycles(timeout_cycles), .int_period(int_period),
    .fallback(fallback), .tick(tick)
  );

  sps_steer u_steer (
    .clk(clk), .rst(rst), .fall_evt(fall_evt), .fallback(fallback), .tick(tick),
    .cycle_start(cycle_start), .start_a(start_ch1), .start_b(start_ch2)
  );

  sps_mode u_mode (
    .clk(clk), .rst(rst), .cycle_start(cycle_start), .lvl(lvl),
    .high_req(high_req), .force_pwm(force_pwm)
  );

endmodule

// File: tb/sim_sync_phase_steer.sv
module sim_sync_phase_steer;
  localparam int CLK_NS = 10;
  localparam int HOLD   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic [15:0] timeout_cycles = 16'd500;
  logic [15:0] int_period = 16'd50;
  logic start_ch1, start_ch2, force_pwm;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sync_phase_steer #(.TMO_W(16), .PER_W(16), .HIGH_HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in), .timeout_cycles(timeout_cycles),
    .int_period(int_period), .start_ch1(start_ch1), .start_ch2(start_ch2),
    .force_pwm(force_pwm)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // falls sync_in, then confirms the strobe lands on the third edge and on the expected channel
  task automatic ext_fall(input bit exp_ch1, input string req);
    @(negedge clk) sync_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3", "early strobe", int'(start_ch1 | start_ch2), 0);
    @(negedge clk);
    chk(req, "start_ch1", int'(start_ch1), int'(exp_ch1));
    chk(req, "start_ch2", int'(start_ch2), int'(!exp_ch1));
    @(negedge clk);
    chk("R3", "strobe width", int'(start_ch1 | start_ch2), 0);
  endtask

  task automatic ext_rise(input int hold);
    @(negedge clk) sync_in = 1'b1;
    repeat (hold) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10", "outputs in reset", int'({start_ch1, start_ch2, force_pwm}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "outputs after reset", int'({start_ch1, start_ch2, force_pwm}), 0);
  endtask

  task automatic t_alternate();
    ext_rise(5); ext_fall(1'b1, "R1");
    ext_rise(5); ext_fall(1'b0, "R2");
    ext_rise(5); ext_fall(1'b1, "R2");
    ext_rise(5); ext_fall(1'b0, "R2");
    chk("R9", "force low on short highs", int'(force_pwm), 0);
  endtask

  task automatic t_fast();
    int na = 0, nb = 0, last = 2, bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i < 32) sync_in = ((i % 4) < 2);
      else sync_in = 1'b0;
      if (start_ch1 && start_ch2) bad++;
      if (start_ch1) begin if (last == 1) bad++; last = 1; na++; end
      if (start_ch2) begin if (last == 2) bad++; last = 2; nb++; end
    end
    chk("R4", "ch1 strobes", na, 4);
    chk("R4", "ch2 strobes", nb, 4);
    chk("R2", "alternation errors", bad, 0);
  endtask

  task automatic t_reset_mid();
    ext_rise(5); ext_fall(1'b1, "R2");
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R10", "outputs in mid reset", int'({start_ch1, start_ch2, force_pwm}), 0);
    rst = 1'b0;
    ext_rise(5); ext_fall(1'b1, "R10");
  endtask

  task automatic t_fallback();
    int first = -1, prev = -1, gap_bad = 0, alt_bad = 0, last = 0;
    timeout_cycles = 16'd30;
    int_period = 16'd10;
    ext_rise(5);
    ext_fall(1'b0, "R2");
    // the sample just taken is one clock past the external strobe
    for (int t = 2; t <= 75; t++) begin
      @(negedge clk);
      if (start_ch1 || start_ch2) begin
        if (first < 0) begin first = t; chk("R5", "first internal on ch1", int'(start_ch1), 1); end
        else if (t - prev != 10) gap_bad++;
        if ((start_ch1 && last == 1) || (start_ch2 && last == 2)) alt_bad++;
        last = start_ch1 ? 1 : 2;
        prev = t;
      end
    end
    chk("R5", "first internal offset", first, 40);
    chk("R5", "internal gap errors", gap_bad, 0);
    chk("R5", "internal alternation errors", alt_bad, 0);
  endtask

  task automatic t_restart();
    int waited = 0;
    while (!start_ch1 && waited < 40) begin @(negedge clk); waited++; end
    chk("R6", "internal ch1 seen", int'(start_ch1), 1);
    ext_rise(2);
    ext_fall(1'b1, "R6");
    ext_rise(5);
    ext_fall(1'b0, "R6");
  endtask

  task automatic t_force();
    int lone_change = 0, seen = 0;
    logic prev_f = 1'b0;
    @(negedge clk) sync_in = 1'b1;
    prev_f = force_pwm;
    for (int t = 0; t < 120; t++) begin
      @(negedge clk);
      if (force_pwm != prev_f && !(start_ch1 || start_ch2)) lone_change++;
      if (force_pwm && !prev_f) seen++;
      prev_f = force_pwm;
    end
    chk("R8", "force set once", seen, 1);
    chk("R8", "force changes without strobe", lone_change, 0);
    chk("R8", "force held while high", int'(force_pwm), 1);
    @(negedge clk) sync_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "force before falling start", int'(force_pwm), 1);
    @(negedge clk);
    chk("R6", "restart on ch1", int'(start_ch1), 1);
    chk("R9", "force released with start", int'(force_pwm), 0);
  endtask

  initial begin
    t_reset();
    t_alternate();
    t_fast();
    t_reset_mid();
    t_fallback();
    t_restart();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule